// File: doc/BRIEF.md
# Motherboard Interrupt Steering Router

This block steers two motherboard interrupt request lines onto chosen inputs of a 16-input interrupt controller, and merges them with the 16 ISA interrupt requests. Each line has its own 8-bit control word, written and read through a small register port. The word sets whether the line is steered, whether it shares its destination with the ISA request already on that input, a pin-mode option that exists only for line 0, and a 4-bit destination code.

When a line is steered with sharing off, the ISA request on the destination is blocked and only the motherboard line drives that controller input. With sharing on, both requests are active-high level signals and they are ORed together. In pin mode, line 0 stops acting as a request input. The block then drives the pin as an output carrying the IRQ0 value, and it takes the IDE interrupt status from ISA IRQ15 instead of from line 0. All outputs are registered on the system clock, so a change of configuration cannot glitch the controller inputs.

Top module: `irq_steer_router`

## Requirements
- R1: After reset both control words read 0x80, pin0_oe is 0, and one clock after each input edge every ctrl_irq bit equals the ISA request with the same index.
- R2: Writing a control word stores bits 7, 6 and 3:0. Bit 4 always reads 0. Bit 5 is stored only for line 0 and reads 0 for line 1. Offset 0 selects line 0 and offset 1 selects line 1.
- R3: Bit 7 is an active-low steering enable. While bit 7 is 1, the line drives nothing and blocks nothing.
- R4: With bit 7 at 0, destination code c in {3,4,5,6,7,9,10,11,12,14,15} (bits 3:0, binary) places the line request on ctrl_irq[c].
- R5: Codes 0, 1, 2, 8 and 13 are reserved. A line holding a reserved code steers nothing and blocks nothing.
- R6: A line that is steered to a valid code with bit 6 (sharing) at 0 blocks the ISA request on that destination, so the input follows the line alone.
- R7: A line that is steered with bit 6 at 1 gives the destination input as the OR of the ISA request and the line request.
- R8: When both lines are steered to the same destination, that input includes the OR of the two line requests.
- R9: Bit 5 of the line 0 word at 1 selects pin mode. pin0_oe is 1, pin0_out carries ISA IRQ0, and line 0 neither steers nor blocks. Whenever pin0_oe is 0, pin0_out is 0.
- R10: ide_irq_stat follows ISA IRQ15 in pin mode, and follows line 0 otherwise.
- R11: Every output changes only at a clock edge. It shows the inputs and configuration that were present at that edge, one cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | 1 | Register offset (0 = line 0, 1 = line 1) |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data of the addressed word |
| mb_irq | input | 2 | Motherboard interrupt request lines |
| isa_irq | input | 16 | ISA interrupt requests |
| ctrl_irq | output | 16 | Interrupt controller inputs |
| pin0_oe | output | 1 | Line 0 pin drives IRQ0 |
| pin0_out | output | 1 | IRQ0 value for the line 0 pin |
| ide_irq_stat | output | 1 | Source signal for the IDE interrupt status flag |

## Verification
A corrupted control word shows up two ways. It appears at once on cfg_rdata, and one cycle later as a wrong ctrl_irq bit: a destination that stays blocked, a request that leaks onto the wrong input, or an ISA line that is not blocked. A fault in the pin-mode bit shows up within one cycle on pin0_oe, pin0_out and ide_irq_stat. For that reason every destination code is swept under each combination of enable, sharing, line level and ISA level, and the destination bit is compared against a model after each edge.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int CFG_W      = 8;
    localparam int CODE_W     = 4;
    localparam int PIN_LINE   = 0;
    localparam int IDE_ALT    = 15;
    localparam int IRQ0_IDX   = 0;

    // Reserved destinations: 0, 1, 2, 8, 13
    localparam logic [15:0] RSVD_CODES = 16'b0010_0001_0000_0111;

    typedef struct packed {
        logic              route_off;
        logic              share;
        logic              pin_mode;
        logic [CODE_W-1:0] code;
    } line_cfg_t;

    function automatic line_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        line_cfg_t c;
        c.route_off = w[7];
        c.share     = w[6];
        c.pin_mode  = w[5];
        c.code      = w[3:0];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input line_cfg_t c);
        return {c.route_off, c.share, c.pin_mode, 1'b0, c.code};
    endfunction

endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_steer_pkg::*;
#(
    parameter int N_LINES = 2,
    parameter int ADDR_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [CFG_W-1:0]             cfg_wdata,
    input  logic                         cfg_we,
    output logic [CFG_W-1:0]             cfg_rdata,
    output line_cfg_t [N_LINES-1:0]      cfg_o
);

    typedef struct packed {
        line_cfg_t [N_LINES-1:0] cfg;
    } regs_t;

    localparam line_cfg_t CFG_RST = '{route_off: 1'b1, share: 1'b0,
                                      pin_mode: 1'b0, code: '0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && (int'(cfg_addr) < N_LINES)) begin
            regs_d.cfg[cfg_addr] = unpack_cfg(cfg_wdata);
            // Pin option exists on one line only
            if (cfg_addr != ADDR_W'(PIN_LINE)) begin
                regs_d.cfg[cfg_addr].pin_mode = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_LINES; k++) begin
                regs_q.cfg[k] <= CFG_RST;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < N_LINES) begin
            cfg_rdata = pack_cfg(regs_q.cfg[cfg_addr]);
        end
    end

    assign cfg_o = regs_q.cfg;

endmodule

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
    import irq_steer_pkg::*;
#(
    parameter int          N_IRQ = 16,
    parameter logic [15:0] RSVD  = RSVD_CODES
) (
    input  line_cfg_t          cfg,
    input  logic               live,
    input  logic               req,
    output logic [N_IRQ-1:0]   route_vec,
    output logic [N_IRQ-1:0]   block_vec
);

    logic steer_on;
    assign steer_on = live && !cfg.route_off;

    for (genvar d = 0; d < N_IRQ; d++) begin : g_dest
        if (RSVD[d]) begin : g_rsvd
            assign route_vec[d] = 1'b0;
            assign block_vec[d] = 1'b0;
        end else begin : g_valid
            logic hit;
            assign hit          = steer_on && (cfg.code == CODE_W'(d));
            assign route_vec[d] = hit && req;
            assign block_vec[d] = hit && !cfg.share;
        end
    end

endmodule

// File: rtl/irq_steer_merge.sv
module irq_steer_merge
    import irq_steer_pkg::*;
#(
    parameter int N_LINES = 2,
    parameter int N_IRQ   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_LINES-1:0][N_IRQ-1:0]   route_bus,
    input  logic [N_LINES-1:0][N_IRQ-1:0]   block_bus,
    input  logic [N_IRQ-1:0]                isa_irq,
    input  logic                            pin_mode,
    input  logic                            line0_req,
    output logic [N_IRQ-1:0]                ctrl_irq,
    output logic                            pin0_oe,
    output logic                            pin0_out,
    output logic                            ide_irq_stat
);

    typedef struct packed {
        logic [N_IRQ-1:0] ctrl;
        logic             oe;
        logic             pout;
        logic             ide;
    } out_t;

    out_t out_d, out_q;
    logic [N_IRQ-1:0] routed, blocked;

    always_comb begin
        routed  = '0;
        blocked = '0;
        for (int k = 0; k < N_LINES; k++) begin
            routed  = routed  | route_bus[k];
            blocked = blocked | block_bus[k];
        end
        out_d.ctrl = (isa_irq & ~blocked) | routed;
        out_d.oe   = pin_mode;
        out_d.pout = pin_mode & isa_irq[IRQ0_IDX];
        out_d.ide  = pin_mode ? isa_irq[IDE_ALT] : line0_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ctrl_irq     = out_q.ctrl;
    assign pin0_oe      = out_q.oe;
    assign pin0_out     = out_q.pout;
    assign ide_irq_stat = out_q.ide;

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int N_LINES = 2,
    parameter int N_IRQ   = 16,
    localparam int ADDR_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 cfg_we,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic [N_LINES-1:0]   mb_irq,
    input  logic [N_IRQ-1:0]     isa_irq,
    output logic [N_IRQ-1:0]     ctrl_irq,
    output logic                 pin0_oe,
    output logic                 pin0_out,
    output logic                 ide_irq_stat
);

    line_cfg_t [N_LINES-1:0]          cfg;
    logic [N_LINES-1:0][N_IRQ-1:0]    route_bus;
    logic [N_LINES-1:0][N_IRQ-1:0]    block_bus;
    logic [N_LINES*CFG_W-1:0]         cfg_word;

    irq_steer_regs #(
        .N_LINES (N_LINES),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_we    (cfg_we),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg)
    );

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        logic live;
        if (k == PIN_LINE) begin : g_pin
            assign live = !cfg[k].pin_mode;
        end else begin : g_plain
            assign live = 1'b1;
        end

        irq_steer_decode #(
            .N_IRQ (N_IRQ)
        ) u_dec (
            .cfg       (cfg[k]),
            .live      (live),
            .req       (mb_irq[k]),
            .route_vec (route_bus[k]),
            .block_vec (block_bus[k])
        );

        assign cfg_word[k*CFG_W +: CFG_W] = pack_cfg(cfg[k]);
    end

    irq_steer_merge #(
        .N_LINES (N_LINES),
        .N_IRQ   (N_IRQ)
    ) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .route_bus    (route_bus),
        .block_bus    (block_bus),
        .isa_irq      (isa_irq),
        .pin_mode     (cfg[PIN_LINE].pin_mode),
        .line0_req    (mb_irq[PIN_LINE]),
        .ctrl_irq     (ctrl_irq),
        .pin0_oe      (pin0_oe),
        .pin0_out     (pin0_out),
        .ide_irq_stat (ide_irq_stat)
    );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
    import irq_steer_pkg::*;
#(
    parameter int N_LINES = 2,
    parameter int N_IRQ   = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_LINES*CFG_W-1:0]    cfg_word,
    input logic [CFG_W-1:0]            cfg_rdata,
    input logic [N_LINES-1:0]          mb_irq,
    input logic [N_IRQ-1:0]            isa_irq,
    input logic [N_IRQ-1:0]            ctrl_irq,
    input logic                        pin0_oe,
    input logic                        pin0_out,
    input logic                        ide_irq_stat
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_rsvd_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[4] == 1'b0);

    assert_oe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin0_oe |-> !pin0_out);

    assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pin0_oe == $past(cfg_word[5]));

    assert_ide_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ide_irq_stat ==
            ($past(cfg_word[5]) ? $past(isa_irq[IDE_ALT]) : $past(mb_irq[0])));

    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_word[7] && cfg_word[CFG_W+7]))
            |-> ctrl_irq == $past(isa_irq));

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_word[7] && !cfg_word[CFG_W+7] && !cfg_word[CFG_W+6]
                          && !RSVD_CODES[cfg_word[CFG_W+3:CFG_W]] && !mb_irq[1]))
            |-> !ctrl_irq[$past(cfg_word[CFG_W+3:CFG_W])]);

endmodule

bind irq_steer_router irq_steer_chk #(
    .N_LINES (N_LINES),
    .N_IRQ   (N_IRQ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .cfg_rdata    (cfg_rdata),
    .mb_irq       (mb_irq),
    .isa_irq      (isa_irq),
    .ctrl_irq     (ctrl_irq),
    .pin0_oe      (pin0_oe),
    .pin0_out     (pin0_out),
    .ide_irq_stat (ide_irq_stat)
);

// File: tb/sim_irq_steer_router.sv
`timescale 1ns/1ps
module sim_irq_steer_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [1:0]  mb_irq = '0;
    logic [15:0] isa_irq = '0;
    logic [15:0] ctrl_irq;
    logic        pin0_oe, pin0_out, ide_irq_stat;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] c0 = 8'h80, c1 = 8'h80;

    always #5 clk = ~clk;

    irq_steer_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .mb_irq(mb_irq),
        .isa_irq(isa_irq), .ctrl_irq(ctrl_irq), .pin0_oe(pin0_oe),
        .pin0_out(pin0_out), .ide_irq_stat(ide_irq_stat)
    );

    function automatic bit code_ok(input logic [3:0] c);
        case (c)
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10,
            4'd11, 4'd12, 4'd14, 4'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] model(input logic [7:0] w0, input logic [7:0] w1,
                                          input logic [1:0] mb, input logic [15:0] isa);
        logic [15:0] rt = '0, bk = '0;
        logic [7:0] w;
        bit live;
        for (int k = 0; k < 2; k++) begin
            w = (k == 0) ? w0 : w1;
            live = !(k == 0 && w0[5]);
            if (live && !w[7] && code_ok(w[3:0])) begin
                if (mb[k]) rt[w[3:0]] = 1'b1;
                if (!w[6]) bk[w[3:0]] = 1'b1;
            end
        end
        return (isa & ~bk) | rt;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        cfg_addr = addr; cfg_wdata = d; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
        if (addr == 1'b0) c0 = d & 8'hEF;
        else              c1 = d & 8'hCF;
    endtask

    task automatic apply(input logic [1:0] mb, input logic [15:0] isa);
        mb_irq = mb; isa_irq = isa;
        step();
    endtask

    task automatic t_reset();
        cfg_addr = 1'b0; #1;
        check("R1 line0 word", {8'h0, cfg_rdata}, 16'h0080);
        cfg_addr = 1'b1; #1;
        check("R1 line1 word", {8'h0, cfg_rdata}, 16'h0080);
        check("R1 oe", {15'h0, pin0_oe}, 16'h0);
        apply(2'b11, 16'hA5C3);
        check("R1 passthru", ctrl_irq, 16'hA5C3);
        apply(2'b00, 16'h5A3C);
        check("R1 passthru2", ctrl_irq, 16'h5A3C);
    endtask

    task automatic t_readback();
        wr(1'b0, 8'hFF);
        cfg_addr = 1'b0; #1;
        check("R2 line0 FF", {8'h0, cfg_rdata}, 16'h00EF);
        wr(1'b1, 8'hFF);
        cfg_addr = 1'b1; #1;
        check("R2 line1 FF", {8'h0, cfg_rdata}, 16'h00CF);
        wr(1'b0, 8'h35);
        cfg_addr = 1'b0; #1;
        check("R2 line0 35", {8'h0, cfg_rdata}, 16'h0025);
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h80);
    endtask

    task automatic t_codes();
        string tag;
        logic [7:0] w;
        for (int en = 0; en < 2; en++)
            for (int sh = 0; sh < 2; sh++)
                for (int code = 0; code < 16; code++) begin
                    w = {(en == 0), (sh == 1), 2'b00, 4'(code)};
                    wr(1'b1, w);
                    for (int m = 0; m < 2; m++)
                        for (int iv = 0; iv < 2; iv++) begin
                            apply({1'(m), 1'b0}, (iv == 1) ? 16'hFFFF : 16'h0000);
                            if (en == 0) tag = "R3 disabled";
                            else if (!code_ok(4'(code))) tag = "R5 reserved";
                            else if (sh == 1) tag = "R7 shared";
                            else tag = (iv == 0) ? "R4 steer" : "R6 block";
                            check(tag, ctrl_irq, model(c0, c1, mb_irq, isa_irq));
                        end
                end
        wr(1'b1, 8'h80);
    endtask

    task automatic t_both();
        wr(1'b0, 8'h4A);
        wr(1'b1, 8'h4A);
        for (int m = 0; m < 4; m++) begin
            apply(2'(m), 16'h0000);
            check("R8 or of lines", ctrl_irq, (m != 0) ? 16'h0400 : 16'h0000);
        end
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h4A);
        apply(2'b10, 16'h0400);
        check("R8 one blocks", ctrl_irq, 16'h0400);
        apply(2'b00, 16'h0400);
        check("R6 blocked by line0", ctrl_irq, 16'h0000);
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h80);
    endtask

    task automatic t_pin();
        apply(2'b01, 16'h0000);
        check("R10 ide from line0", {15'h0, ide_irq_stat}, 16'h1);
        check("R9 oe off", {14'h0, pin0_oe, pin0_out}, 16'h0);
        apply(2'b00, 16'h8001);
        check("R10 ide ignores irq15", {15'h0, ide_irq_stat}, 16'h0);
        wr(1'b0, 8'h25);
        apply(2'b01, 16'h0001);
        check("R9 oe+irq0", {14'h0, pin0_oe, pin0_out}, 16'h3);
        check("R9 line0 no steer", ctrl_irq, 16'h0001);
        check("R10 ide from irq15 lo", {15'h0, ide_irq_stat}, 16'h0);
        apply(2'b00, 16'h8020);
        check("R9 irq0 low", {14'h0, pin0_oe, pin0_out}, 16'h2);
        check("R9 line0 no block", ctrl_irq, 16'h8020);
        check("R10 ide from irq15 hi", {15'h0, ide_irq_stat}, 16'h1);
        wr(1'b0, 8'h80);
        apply(2'b00, 16'h0001);
        check("R9 oe released", {14'h0, pin0_oe, pin0_out}, 16'h0);
    endtask

    task automatic t_latency();
        wr(1'b1, 8'h05);
        apply(2'b10, 16'h0000);
        check("R11 settled", ctrl_irq, 16'h0020);
        mb_irq = 2'b00; isa_irq = 16'h0003; #1;
        check("R11 held before edge", ctrl_irq, 16'h0020);
        step();
        check("R11 after edge", ctrl_irq, 16'h0003);
        cfg_addr = 1'b1; cfg_wdata = 8'h80; cfg_we = 1'b1; mb_irq = 2'b10;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; c1 = 8'h80;
        check("R11 cfg one cycle late", ctrl_irq, 16'h0023);
        step();
        check("R11 cfg applied", ctrl_irq, 16'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_codes();
        t_both();
        t_pin();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule